// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Controller

This block is the device-side control logic for a single bulk OUT endpoint. Software loads a transfer length while the endpoint is idle, sets the arm bit, and supplies a maximum packet size. Incoming data packets arrive on a simple abstracted receive interface: one strobe per received byte and a marker on the cycle that ends the packet. For each packet the block decides whether to answer ACK or NAK. It reduces the remaining length by the number of bytes actually taken, ends the transfer on a short packet or when the count reaches zero, disarms itself, and records the outcome in sticky status bits that drive an interrupt line.

The block does not hold the packet data. It issues a one-cycle write strobe per byte that an external endpoint buffer can use. While the endpoint is disarmed, no strobes are issued and every packet is refused. A packet that carries more bytes than remain in the transfer is refused and leaves all state untouched. The host is expected to retry such a packet.

Top module: `usb_bulk_out_ep`

## Requirements
- R1: After a synchronous reset the remaining length is 0, the endpoint is disarmed, all status bits and the interrupt are 0, and no handshake is presented.
- R2: A length write loads the remaining length only while the endpoint is disarmed; a length write while armed leaves the remaining length unchanged.
- R3: An accepted packet reduces the remaining length by exactly the number of bytes it carried (length 320, packet size 64, packets 64+64+64+64+3 bytes leave 61).
- R4: An accepted packet of full maximum size that leaves a nonzero remaining length is ACKed, sets only the packet-complete bit (status bit 0), and the endpoint stays armed.
- R5: An accepted packet shorter than the maximum size, including a zero-length packet, is ACKed, sets packet-complete (bit 0) and transfer-complete (bit 1), does not set byte-count-zero (bit 2), and disarms the endpoint.
- R6: An accepted full-size packet that brings the remaining length to 0 is ACKed, sets bits 0, 1 and 2, and disarms the endpoint.
- R7: A packet that ends while the endpoint is disarmed is NAKed, leaves the remaining length and status unchanged, and produces no buffer write strobes.
- R8: A packet carrying more bytes than the remaining length is NAKed, and the remaining length, arm bit and status are left unchanged.
- R9: Status bits are sticky and cleared by writing one to the matching bit of the clear input; a set and a clear of the same bit in the same cycle leaves it set; the interrupt output is high whenever any status bit is set.
- R10: The handshake strobe is high for exactly one cycle, the cycle after the end-of-packet marker, with the ACK/NAK decision (1 = ACK) valid alongside it.
- R11: While armed, each received byte produces one buffer write strobe one cycle after its byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_we | input | 1 | Write strobe for the transfer length |
| len_wdata | input | LEN_W | Transfer length in bytes |
| arm_set | input | 1 | Arms the endpoint |
| mps_cfg | input | MPS_W | Maximum packet size in bytes |
| sts_clr | input | 3 | Write-one-to-clear for status bits |
| rx_byte_vld | input | 1 | One received data byte this cycle |
| rx_pkt_end | input | 1 | Current cycle ends the data packet (its byte strobe, if any, is counted) |
| hs_valid | output | 1 | Handshake decision presented |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| buf_we | output | 1 | Buffer write strobe for a received byte |
| rem_len | output | LEN_W | Remaining transfer length |
| armed | output | 1 | Endpoint arm bit |
| status | output | 3 | bit0 packet complete, bit1 transfer complete, bit2 byte count zero |
| irq | output | 1 | Any status bit set |

## Verification
The bench builds the block with a 10-bit length field and an 8-bit packet-size field. The narrow length field keeps the lengths small, while the packet-size field still holds the sizes 64 and 8. The 320-byte transfer ending in a 3-byte packet runs at size 64, as do the overflow refusals and the exact-zero case. The smaller size of 8 shows that the short-packet rule follows the configured value and not a fixed one.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int ST_PC  = 0;
  localparam int ST_TC  = 1;
  localparam int ST_BCZ = 2;
  localparam int ST_W   = 3;
endpackage

// File: rtl/ep_byte_counter.sv
module ep_byte_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic             pkt_end,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] cnt_q;

  // running byte count including this cycle's byte, saturating
  always_comb begin
    if (byte_vld && (cnt_q != {CNT_W{1'b1}}))
      total = cnt_q + 1'b1;
    else
      total = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (pkt_end) cnt_q <= '0;
    else              cnt_q <= total;
  end

  assert_restart_after_end_R3: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> (cnt_q == '0));
endmodule

// File: rtl/ep_xfer_ctrl.sv
module ep_xfer_ctrl #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             arm_set,
  input  logic [MPS_W-1:0] mps,
  input  logic             byte_vld,
  input  logic             pkt_end,
  input  logic [LEN_W:0]   total,
  output logic [LEN_W-1:0] rem_q,
  output logic             armed_q,
  output logic             hs_valid_q,
  output logic             hs_ack_q,
  output logic             buf_we_q,
  output logic             set_pc,
  output logic             set_tc,
  output logic             set_bcz
);
  localparam int TW = LEN_W + 1;

  logic             fits, accept, is_short, hits_zero;
  logic [LEN_W-1:0] rem_after;
  logic [TW-1:0]    mps_ext;

  assign mps_ext   = TW'(mps);
  assign fits      = total <= {1'b0, rem_q};
  assign accept    = pkt_end && armed_q && fits;
  assign rem_after = rem_q - total[LEN_W-1:0];
  assign is_short  = total < mps_ext;
  assign hits_zero = (rem_after == '0);

  assign set_pc  = accept;
  assign set_tc  = accept && (is_short || hits_zero);
  assign set_bcz = accept && hits_zero && !is_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q      <= '0;
      armed_q    <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_ack_q   <= 1'b0;
      buf_we_q   <= 1'b0;
    end else begin
      if (accept)
        rem_q <= rem_after;
      else if (len_we && !armed_q)
        rem_q <= len_wdata;
      armed_q    <= arm_set || (armed_q && !set_tc);
      hs_valid_q <= pkt_end;
      hs_ack_q   <= accept;
      buf_we_q   <= byte_vld && armed_q;
    end
  end

  assert_nak_when_disarmed_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_end && !armed_q) |=> (hs_valid_q && !hs_ack_q));

  assert_nak_keeps_len_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_valid_q && !hs_ack_q) |-> (rem_q == $past(rem_q) || $past(len_we && !armed_q)));

  assert_len_wr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (len_we && armed_q && !pkt_end) |=> (rem_q == $past(rem_q)));

  assert_short_disarms_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_end && armed_q && !arm_set && total < mps_ext && total <= {1'b0, rem_q})
      |=> (!armed_q && hs_ack_q));

  assert_hs_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (hs_valid_q && !$past(pkt_end, 1)) |-> 1'b0);
endmodule

// File: rtl/ep_status_regs.sv
module ep_status_regs
  import usb_ep_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] set_bits,
  input  logic [ST_W-1:0] clr_bits,
  output logic [ST_W-1:0] sts_q,
  output logic            irq_q
);
  logic [ST_W-1:0] sts_next;

  assign sts_next = (sts_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_next;
      irq_q <= |sts_next;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_bits)) == $past(sts_q & ~clr_bits)));

  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == (sts_q != '0));
endmodule

// File: rtl/usb_bulk_out_ep.sv
module usb_bulk_out_ep
  import usb_ep_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             arm_set,
  input  logic [MPS_W-1:0] mps_cfg,
  input  logic [2:0]       sts_clr,
  input  logic             rx_byte_vld,
  input  logic             rx_pkt_end,
  output logic             hs_valid,
  output logic             hs_ack,
  output logic             buf_we,
  output logic [LEN_W-1:0] rem_len,
  output logic             armed,
  output logic [2:0]       status,
  output logic             irq
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] total;
  logic             set_pc, set_tc, set_bcz;
  logic [ST_W-1:0]  set_bits;

  ep_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (rx_byte_vld),
    .pkt_end  (rx_pkt_end),
    .total    (total)
  );

  ep_xfer_ctrl #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .len_we     (len_we),
    .len_wdata  (len_wdata),
    .arm_set    (arm_set),
    .mps        (mps_cfg),
    .byte_vld   (rx_byte_vld),
    .pkt_end    (rx_pkt_end),
    .total      (total),
    .rem_q      (rem_len),
    .armed_q    (armed),
    .hs_valid_q (hs_valid),
    .hs_ack_q   (hs_ack),
    .buf_we_q   (buf_we),
    .set_pc     (set_pc),
    .set_tc     (set_tc),
    .set_bcz    (set_bcz)
  );

  always_comb begin
    set_bits         = '0;
    set_bits[ST_PC]  = set_pc;
    set_bits[ST_TC]  = set_tc;
    set_bits[ST_BCZ] = set_bcz;
  end

  ep_status_regs u_sts (
    .clk      (clk),
    .rst      (rst),
    .set_bits (set_bits),
    .clr_bits (sts_clr),
    .sts_q    (status),
    .irq_q    (irq)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!armed && rem_len == '0 && status == '0 && !hs_valid && !irq));

  assert_no_we_disarmed_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_byte_vld && !armed) |=> !buf_we);
endmodule

// File: tb/usb_bulk_out_ep_tb.sv
module usb_bulk_out_ep_tb;
  localparam int LEN_W = 10;
  localparam int MPS_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             len_we = 1'b0;
  logic [LEN_W-1:0] len_wdata = '0;
  logic             arm_set = 1'b0;
  logic [MPS_W-1:0] mps_cfg = 8'd64;
  logic [2:0]       sts_clr = 3'b000;
  logic             rx_byte_vld = 1'b0;
  logic             rx_pkt_end = 1'b0;
  logic             hs_valid, hs_ack, buf_we, armed, irq;
  logic [LEN_W-1:0] rem_len;
  logic [2:0]       status;

  int n_checks = 0;
  int n_fail   = 0;
  int we_cnt   = 0;
  bit done     = 1'b0;

  usb_bulk_out_ep #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_dut (
    .clk(clk), .rst(rst), .len_we(len_we), .len_wdata(len_wdata),
    .arm_set(arm_set), .mps_cfg(mps_cfg), .sts_clr(sts_clr),
    .rx_byte_vld(rx_byte_vld), .rx_pkt_end(rx_pkt_end),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .buf_we(buf_we),
    .rem_len(rem_len), .armed(armed), .status(status), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) we_cnt <= we_cnt + (buf_we ? 1 : 0);

  // vector table: bytes, ACK, remaining, status, armed (length 320, size 64)
  localparam int VN = 6;
  localparam int V_BYTES [VN] = '{64, 64, 64, 64, 3, 10};
  localparam int V_ACK   [VN] = '{1, 1, 1, 1, 1, 0};
  localparam int V_REM   [VN] = '{256, 192, 128, 64, 61, 61};
  localparam int V_STS   [VN] = '{1, 1, 1, 1, 3, 0};
  localparam int V_ARM   [VN] = '{1, 1, 1, 1, 0, 0};

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_len(input int v);
    @(negedge clk); len_we = 1'b1; len_wdata = LEN_W'(v);
    @(negedge clk); len_we = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm_set = 1'b1;
    @(negedge clk); arm_set = 1'b0;
  endtask

  task automatic clear_sts(input logic [2:0] m);
    @(negedge clk); sts_clr = m;
    @(negedge clk); sts_clr = 3'b000;
  endtask

  // sends n bytes; on return the handshake cycle has just been sampled
  task automatic send_pkt(input int n, input logic [2:0] clr_at_end,
                          output int hv, output int ha, output int we_n);
    int base;
    @(negedge clk);
    base = we_cnt;
    if (n == 0) begin
      rx_pkt_end = 1'b1; sts_clr = clr_at_end;
    end else begin
      for (int i = 0; i < n; i++) begin
        if (i > 0) @(negedge clk);
        rx_byte_vld = 1'b1;
        rx_pkt_end  = (i == n - 1);
        if (i == n - 1) sts_clr = clr_at_end;
      end
    end
    @(negedge clk);
    rx_byte_vld = 1'b0; rx_pkt_end = 1'b0; sts_clr = 3'b000;
    hv = int'(hs_valid); ha = int'(hs_ack);
    @(negedge clk);
    we_n = we_cnt - base;
    chk("R10 handshake pulse ends", int'(hs_valid), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int hv, ha, wn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rem", int'(rem_len), 0);
    chk("R1 armed", int'(armed), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 hs_valid", int'(hs_valid), 0);
    chk("R1 irq", int'(irq), 0);

    // table-driven transfer: 320 bytes, size 64
    write_len(320);
    chk("R2 load while disarmed", int'(rem_len), 320);
    do_arm();
    for (int v = 0; v < VN; v++) begin
      clear_sts(3'b111);
      send_pkt(V_BYTES[v], 3'b000, hv, ha, wn);
      chk("R10 hs_valid", hv, 1);
      chk("R3/R4/R5/R7 ack", ha, V_ACK[v]);
      chk("R3 rem", int'(rem_len), V_REM[v]);
      chk("R4/R5/R7 status", int'(status), V_STS[v]);
      chk("R4/R5 armed", int'(armed), V_ARM[v]);
      chk("R11/R7 buffer strobes", wn, V_ARM[v] == 1 || V_ACK[v] == 1 ? V_BYTES[v] : 0);
    end

    // R2: length write ignored while armed
    clear_sts(3'b111);
    write_len(100);
    do_arm();
    write_len(50);
    chk("R2 write ignored while armed", int'(rem_len), 100);

    // R8: overflow is refused
    send_pkt(101, 3'b000, hv, ha, wn);
    chk("R8 nak", ha, 0);
    chk("R8 rem", int'(rem_len), 100);
    chk("R8 armed", int'(armed), 1);
    chk("R8 status", int'(status), 0);
    send_pkt(64, 3'b000, hv, ha, wn);
    chk("R4 ack", ha, 1);
    chk("R4 rem", int'(rem_len), 36);
    chk("R4 status", int'(status), 1);
    chk("R4 armed", int'(armed), 1);
    clear_sts(3'b111);
    send_pkt(40, 3'b000, hv, ha, wn);
    chk("R8 nak 40", ha, 0);
    chk("R8 rem 36", int'(rem_len), 36);
    chk("R8 status kept", int'(status), 0);
    send_pkt(36, 3'b000, hv, ha, wn);
    chk("R5 ack", ha, 1);
    chk("R5 rem", int'(rem_len), 0);
    chk("R5 status no bcz", int'(status), 3);
    chk("R5 disarmed", int'(armed), 0);

    // R6: exact zero with full packets
    clear_sts(3'b111);
    write_len(128);
    do_arm();
    send_pkt(64, 3'b000, hv, ha, wn);
    send_pkt(64, 3'b000, hv, ha, wn);
    chk("R6 ack", ha, 1);
    chk("R6 rem", int'(rem_len), 0);
    chk("R6 status", int'(status), 7);
    chk("R6 disarmed", int'(armed), 0);

    // R5: zero-length packet
    clear_sts(3'b111);
    write_len(10);
    do_arm();
    send_pkt(0, 3'b000, hv, ha, wn);
    chk("R5 zlp ack", ha, 1);
    chk("R5 zlp rem", int'(rem_len), 10);
    chk("R5 zlp status", int'(status), 3);
    chk("R5 zlp disarmed", int'(armed), 0);

    // R9: partial clear, irq, set wins over clear
    chk("R9 irq set", int'(irq), 1);
    clear_sts(3'b001);
    chk("R9 partial clear", int'(status), 2);
    chk("R9 irq still", int'(irq), 1);
    write_len(20);
    do_arm();
    send_pkt(8, 3'b111, hv, ha, wn);
    chk("R9 set wins", int'(status), 3);
    clear_sts(3'b111);
    chk("R9 cleared", int'(status), 0);
    chk("R9 irq low", int'(irq), 0);

    // R5 with packet size 8
    mps_cfg = 8'd8;
    write_len(20);
    do_arm();
    send_pkt(8, 3'b000, hv, ha, wn);
    chk("R4 size8 rem", int'(rem_len), 12);
    chk("R4 size8 armed", int'(armed), 1);
    chk("R4 size8 status", int'(status), 1);
    send_pkt(8, 3'b000, hv, ha, wn);
    clear_sts(3'b111);
    send_pkt(4, 3'b000, hv, ha, wn);
    chk("R5 size8 rem", int'(rem_len), 0);
    chk("R5 size8 status", int'(status), 3);
    chk("R5 size8 disarmed", int'(armed), 0);

    // R7: disarmed packet, no strobes
    send_pkt(5, 3'b000, hv, ha, wn);
    chk("R7 nak", ha, 0);
    chk("R7 strobes", wn, 0);
    chk("R7 status", int'(status), 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule